// File: doc/BRIEF.md
# Multi-Channel Wake Output Controller

This block merges the wake flags of several receive channels into one active-low wake pin that is modelled as an open-drain driver. A pull-up outside the block sets the pin level: the pin reads high unless the block drives it low. Software releases the pin by holding a clear bit at 1 and then setting it back to 0. While the bit is 1, every channel correlator receives a continuous clear. After power-on reset the pin is asserted, so the first clear sequence from software is required.

For bring-up and diagnosis, a test path can route signals of one selected channel to the wake pin instead of the merged wake. These are the detector data stream or that channel's own wake flag. The same level can also go to a secondary pin that has a separate output enable. That enable is gated by the active-low chip select and by an output-mode field. The block registers all outputs once, so each output shows the inputs sampled at the previous clock edge.

Top module: `wake_out_ctrl`

## Requirements
- R1: With `test_en`=0 and `wake_clr`=0, `wake_drv_lo` is 1 exactly when at least one bit of `ch_wake` is 1 or the power-on wake is still pending. `wake_pin` is always the inverse of `wake_drv_lo`.
- R2: When `wake_clr`=1 is sampled, the next cycle has `wake_drv_lo`=0. This holds in normal mode and in every test routing of a wake signal.
- R3: During reset `wake_drv_lo`=1. The power-on wake stays pending until `wake_clr`=1 is sampled once. After that, a return of `wake_clr` to 0 with no channel flag set leaves the pin released.
- R4: With `test_en`=1 and `test_sel`=00, the pin level (`wake_pin`) equals the data bit of the selected channel. Clear does not affect this path.
- R5: With `test_en`=1 and `test_sel`=01, the pin is driven low exactly when the selected channel's own flag is 1 and `wake_clr`=0. The flags of the other channels have no effect.
- R6: `ch_sel` 00, 01 and 10 select channel 1, 2 and 3 (bit 0, 1 and 2 of the channel vectors). In test mode `ch_sel`=11 routes the merged, clear-gated wake, which also includes the pending power-on wake.
- R7: With `test_en`=1 and `test_sel` equal to 10 or 11, the pin is released (`wake_drv_lo`=0).
- R8: `corr_clr` is all ones in the cycle after `wake_clr`=1 is sampled and all zeros in the cycle after `wake_clr`=0 is sampled. It is all ones during reset.
- R9: `sec_oe` is 1 only after a cycle that sampled `cs_n`=0 together with `out_mode`=10. Mode codes 00, 01 and 11 keep it 0, and it is 0 during reset.
- R10: `sec_do` always equals the pin level, that is `wake_pin`.
- R11: Outputs change only at a clock edge and reflect the inputs sampled at that edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| ch_wake | input | 3 | Per-channel wake flags from the correlators |
| ch_data | input | 3 | Per-channel detector data bits |
| ch_sel | input | 2 | Channel select; 11 = merged wake in test mode |
| test_en | input | 1 | Enables test routing onto the wake pin |
| test_sel | input | 2 | Test routing: 00 data, 01 single wake, 10/11 released |
| out_mode | input | 2 | Secondary pin mode: 10 digital, others high impedance |
| wake_clr | input | 1 | Level-held clear bit |
| cs_n | input | 1 | Active-low chip select gating the secondary pin |
| wake_drv_lo | output | 1 | Open-drain pull-down enable for the wake pin |
| wake_pin | output | 1 | Resulting wake pin level with the pull-up |
| corr_clr | output | 3 | Clear to each channel correlator |
| sec_oe | output | 1 | Secondary pin output enable |
| sec_do | output | 1 | Secondary pin data |

## Verification
Two functions can fall in the same cycle: a clear and a fresh wake flag, or a clear and the pending power-on wake. In both cases the clear must win for one cycle. When the bit drops, the flag that is still held must assert the pin again, and the power-on wake must not come back. The bench provokes this by raising a channel flag in the same cycle that `wake_clr` rises and falls. It also sweeps random combinations of flags, clear, routing and select. A behavioural model computes the expected outputs and is compared on every clock.

// File: rtl/wake_ctrl_pkg.sv
package wake_ctrl_pkg;

   typedef enum logic [1:0] {
      TS_DATA  = 2'b00,
      TS_WAKE  = 2'b01,
      TS_RSV_A = 2'b10,
      TS_RSV_B = 2'b11
   } test_route_e;

   typedef enum logic [1:0] {
      OM_HIZ     = 2'b00,
      OM_ANALOG  = 2'b01,
      OM_DIGITAL = 2'b10,
      OM_UNUSED  = 2'b11
   } sec_mode_e;

   typedef struct packed {
      logic drv_lo;
      logic sec_oe;
      logic sec_do;
   } pin_bundle_t;

endpackage

// File: rtl/wake_merge.sv
module wake_merge #(
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_wake,
   input  logic              wake_clr,
   output logic              wake_any,
   output logic [NUM_CH-1:0] wake_ind
);

   logic por_pend_q;
   logic por_pend_nxt;

   // the power-on wake stays until a clear level is seen
   assign por_pend_nxt = por_pend_q & ~wake_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) por_pend_q <= 1'b1;
      else        por_pend_q <= por_pend_nxt;
   end

   assign wake_any = (por_pend_nxt | (|ch_wake)) & ~wake_clr;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ind
      assign wake_ind[g] = ch_wake[g] & ~wake_clr;
   end

endmodule

// File: rtl/wake_route_mux.sv
module wake_route_mux
   import wake_ctrl_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int SEL_W  = 2
) (
   input  logic              test_en,
   input  logic [1:0]        test_sel,
   input  logic [SEL_W-1:0]  ch_sel,
   input  logic [NUM_CH-1:0] ch_data,
   input  logic              wake_any,
   input  logic [NUM_CH-1:0] wake_ind,
   output logic              pin_lvl
);

   logic sel_valid;
   logic sel_data;
   logic sel_wake;

   always_comb begin
      sel_valid = 1'b0;
      sel_data  = 1'b1;
      sel_wake  = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_sel == SEL_W'(i)) begin
            sel_valid = 1'b1;
            sel_data  = ch_data[i];
            sel_wake  = wake_ind[i];
         end
      end
   end

   always_comb begin
      if (!test_en) begin
         pin_lvl = ~wake_any;
      end else begin
         unique case (test_route_e'(test_sel))
            TS_DATA:  pin_lvl = sel_valid ? sel_data  : ~wake_any;
            TS_WAKE:  pin_lvl = sel_valid ? ~sel_wake : ~wake_any;
            default:  pin_lvl = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/wake_out_stage.sv
module wake_out_stage
   import wake_ctrl_pkg::*;
#(
   parameter int NUM_CH  = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_lvl,
   input  logic              sec_en,
   input  logic              wake_clr,
   output logic              wake_drv_lo,
   output logic              sec_oe,
   output logic              sec_do,
   output logic [NUM_CH-1:0] corr_clr
);

   localparam pin_bundle_t RST_PINS = '{drv_lo: 1'b1, sec_oe: 1'b0, sec_do: 1'b0};

   pin_bundle_t       pins_nxt;
   pin_bundle_t       pins_q;
   logic [NUM_CH-1:0] clr_nxt;
   logic [NUM_CH-1:0] clr_q;

   assign pins_nxt = '{drv_lo: ~pin_lvl, sec_oe: sec_en, sec_do: pin_lvl};
   assign clr_nxt  = {NUM_CH{wake_clr}};

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pins_q <= RST_PINS;
            clr_q  <= '1;
         end else begin
            pins_q <= pins_nxt;
            clr_q  <= clr_nxt;
         end
      end
   end else begin : g_comb
      always_comb begin
         pins_q = rst_n ? pins_nxt : RST_PINS;
         clr_q  = rst_n ? clr_nxt  : '1;
      end
   end

   assign wake_drv_lo = pins_q.drv_lo;
   assign sec_oe      = pins_q.sec_oe;
   assign sec_do      = pins_q.sec_do;
   assign corr_clr    = clr_q;

endmodule

// File: rtl/wake_out_ctrl.sv
module wake_out_ctrl
   import wake_ctrl_pkg::*;
#(
   parameter int NUM_CH  = 3,
   parameter bit OUT_REG = 1'b1,
   localparam int SEL_W  = $clog2(NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_wake,
   input  logic [NUM_CH-1:0] ch_data,
   input  logic [SEL_W-1:0]  ch_sel,
   input  logic              test_en,
   input  logic [1:0]        test_sel,
   input  logic [1:0]        out_mode,
   input  logic              wake_clr,
   input  logic              cs_n,
   output logic              wake_drv_lo,
   output logic              wake_pin,
   output logic [NUM_CH-1:0] corr_clr,
   output logic              sec_oe,
   output logic              sec_do
);

   if (NUM_CH < 1 || NUM_CH > 15) begin : g_bad_ch
      $error("wake_out_ctrl: NUM_CH out of range");
   end

   logic              wake_any;
   logic [NUM_CH-1:0] wake_ind;
   logic              pin_lvl;
   logic              sec_en;

   wake_merge #(.NUM_CH(NUM_CH)) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch_wake  (ch_wake),
      .wake_clr (wake_clr),
      .wake_any (wake_any),
      .wake_ind (wake_ind)
   );

   wake_route_mux #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_mux (
      .test_en  (test_en),
      .test_sel (test_sel),
      .ch_sel   (ch_sel),
      .ch_data  (ch_data),
      .wake_any (wake_any),
      .wake_ind (wake_ind),
      .pin_lvl  (pin_lvl)
   );

   assign sec_en = ~cs_n & (sec_mode_e'(out_mode) == OM_DIGITAL);

   wake_out_stage #(.NUM_CH(NUM_CH), .OUT_REG(OUT_REG)) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_lvl     (pin_lvl),
      .sec_en      (sec_en),
      .wake_clr    (wake_clr),
      .wake_drv_lo (wake_drv_lo),
      .sec_oe      (sec_oe),
      .sec_do      (sec_do),
      .corr_clr    (corr_clr)
   );

   // pull-up: the pin is high whenever nothing pulls it down
   assign wake_pin = ~wake_drv_lo;

   if (OUT_REG) begin : g_chk
      AST_OR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
         (!test_en && !wake_clr && (|ch_wake)) |=> wake_drv_lo); // R1
      AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
         (wake_clr && !(test_en && test_sel == 2'b00 && ch_sel != '1)) |=> !wake_drv_lo); // R2
      AST_RSV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
         (test_en && test_sel[1]) |=> !wake_drv_lo); // R7
      AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
         wake_clr |=> (&corr_clr)); // R8
      AST_CLR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
         !wake_clr |=> (corr_clr == '0)); // R8
      AST_SEC_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
         (cs_n || out_mode != 2'b10) |=> !sec_oe); // R9
      AST_SEC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (sec_do == wake_pin)); // R10
   end

endmodule

// File: tb/tb_wake_out_ctrl.sv
module tb_wake_out_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ch_wake = '0;
   logic [2:0] ch_data = '0;
   logic [1:0] ch_sel = '0;
   logic       test_en = 1'b0;
   logic [1:0] test_sel = '0;
   logic [1:0] out_mode = '0;
   logic       wake_clr = 1'b1;
   logic       cs_n = 1'b1;
   logic       wake_drv_lo;
   logic       wake_pin;
   logic [2:0] corr_clr;
   logic       sec_oe;
   logic       sec_do;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // behavioural model state
   bit         m_por;
   bit         m_drv;
   bit [2:0]   m_clr;
   bit         m_oe;
   bit         m_do;

   always #2 clk = ~clk;

   wake_out_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ch_wake(ch_wake), .ch_data(ch_data),
      .ch_sel(ch_sel), .test_en(test_en), .test_sel(test_sel),
      .out_mode(out_mode), .wake_clr(wake_clr), .cs_n(cs_n),
      .wake_drv_lo(wake_drv_lo), .wake_pin(wake_pin), .corr_clr(corr_clr),
      .sec_oe(sec_oe), .sec_do(sec_do)
   );

   task automatic model_reset();
      m_por = 1; m_drv = 1; m_clr = 3'b111; m_oe = 0; m_do = 0;
   endtask

   task automatic model_step();
      bit any_w;
      bit lvl;
      int s;
      m_por = m_por && !wake_clr;
      any_w = (m_por || (ch_wake != 0)) && !wake_clr;
      s = int'(ch_sel);
      if (!test_en) lvl = !any_w;
      else if (test_sel == 2'b00) lvl = (s < 3) ? ch_data[s] : !any_w;
      else if (test_sel == 2'b01) lvl = (s < 3) ? !(ch_wake[s] && !wake_clr) : !any_w;
      else lvl = 1;
      m_drv = !lvl;
      m_do  = lvl;
      m_oe  = !cs_n && out_mode == 2'b10;
      m_clr = wake_clr ? 3'b111 : 3'b000;
   endtask

   task automatic check1(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      check1(tag, "wake_drv_lo", int'(wake_drv_lo), int'(m_drv));
      check1("R1", "wake_pin", int'(wake_pin), int'(!m_drv));
      check1("R8", "corr_clr", int'(corr_clr), int'(m_clr));
      check1("R9", "sec_oe", int'(sec_oe), int'(m_oe));
      check1("R10", "sec_do", int'(sec_do), int'(m_do));
   endtask

   // inputs are already set at a falling edge; one rising edge, then compare
   task automatic tick(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      model_reset();
      repeat (3) @(negedge clk);
      compare("R3");                          // reset state: R3, R8, R9
      check1("R3", "reset pin", int'(wake_pin), 0);
      rst_n = 1'b1;

      // power-on wake still pending with clear held? clear is 1 here
      wake_clr = 1'b0; tick("R3");            // pending wake asserted
      check1("R3", "pending pin", int'(wake_pin), 0);
      wake_clr = 1'b1; tick("R2");            // clear releases
      wake_clr = 1'b0; tick("R3");            // stays released
      check1("R3", "after toggle", int'(wake_pin), 1);

      // R1: each channel alone, then several
      for (int c = 0; c < 3; c++) begin
         ch_wake = 3'(1 << c); tick("R1");
         ch_wake = '0;         tick("R1");
      end
      ch_wake = 3'b101; tick("R1");

      // clear and new flag in the same cycle: clear wins, flag returns
      wake_clr = 1'b1; ch_wake = 3'b010; tick("R2");
      wake_clr = 1'b0; tick("R1");
      wake_clr = 1'b1; tick("R11");
      ch_wake = '0; wake_clr = 1'b0; tick("R11");

      // R4 / R6 data routing
      test_en = 1; test_sel = 2'b00;
      for (int s = 0; s < 3; s++) begin
         ch_sel = 2'(s);
         ch_data = 3'(1 << s); tick("R4");
         ch_data = ~3'(1 << s); tick("R6");
      end
      ch_sel = 2'b11; ch_wake = 3'b100; tick("R6");
      ch_wake = '0; tick("R6");
      wake_clr = 1; ch_sel = 2'b01; ch_data = 3'b000; tick("R4");

      // R5 single wake, others ignored
      wake_clr = 0; test_sel = 2'b01; ch_sel = 2'b10;
      ch_wake = 3'b011; tick("R5");
      ch_wake = 3'b100; tick("R5");
      wake_clr = 1; tick("R2");
      wake_clr = 0; tick("R5");
      ch_sel = 2'b00; tick("R6");

      // R7 reserved routings release
      test_sel = 2'b10; ch_wake = 3'b111; tick("R7");
      test_sel = 2'b11; tick("R7");

      // R9 secondary pin modes
      test_en = 0;
      for (int m = 0; m < 4; m++) begin
         out_mode = 2'(m);
         cs_n = 0; tick("R9");
         cs_n = 1; tick("R9");
      end

      // mixed sweep
      for (int k = 0; k < 400; k++) begin
         ch_wake  = 3'($urandom & 7);
         if (($urandom % 4) != 0) ch_wake = '0;
         ch_data  = 3'($urandom & 7);
         ch_sel   = 2'($urandom & 3);
         test_en  = 1'($urandom & 1);
         test_sel = 2'($urandom & 3);
         out_mode = 2'($urandom & 3);
         wake_clr = (($urandom % 5) == 0);
         cs_n     = 1'($urandom & 1);
         tick("R11");
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule